// File: doc/BRIEF.md
# Read-Transfer Sequence Monitor

This block watches the strobes of a single framed read transfer and decides, cycle by cycle, whether the transfer follows its expected shape. A transfer opens with a one-cycle request. The responder acknowledges on the very next cycle and then stays quiet for a bounded gap of one to four cycles. After that gap it marks completion. A data phase of strobed beats follows, and an end marker closes the transfer. Only the strobes are judged; the data values themselves are never examined.

A two-bit mode input selects how the completion cycle, the data phase and the end marker are joined:
- **Split joining:** the data phase starts on the cycle after completion.
- **Leading joining:** the first data beat must share the completion cycle.
- **Fused joining:** the end marker must arrive together with the last data beat.

When a transfer closes correctly the monitor emits a one-cycle success pulse. When a rule is broken it emits a one-cycle error pulse with a code and returns to idle. The block sits beside a bus as a passive observer. Transfers are assumed not to overlap; a new request during an open transfer is itself reported.

Top module: `seq_read_mon`

## Requirements
- R1: A synchronous active-high reset returns the monitor to idle with `xfer_ok`, `err_pulse` and `err_code` all zero. Completion or end strobes seen after reset and without a new request produce no pulse.
- R2: On the cycle right after a request, `ack` must be high. If it is low, the error code is 1 (no acknowledge).
- R3: Completion (`done`) is accepted on the 2nd through 5th cycle after the acknowledge cycle. A `done` on the 1st cycle after the acknowledge counts as an ordinary gap cycle and is ignored.
- R4: If `done` has not arrived by the 5th cycle after the acknowledge cycle, the error code is 2 (completion late).
- R5: Modes 0 and 3 use split joining. The completion cycle's other strobes are ignored. Zero or more `data` beats follow, and the first cycle with `endl` closes the transfer with an `xfer_ok` pulse.
- R6: Mode 1 uses leading joining. The completion cycle must also carry `data`, otherwise the error code is 3 (framing). Later cycles follow the split rules, closing on `endl`.
- R7: Mode 2 uses fused joining. From the completion cycle on, every cycle must carry `data`, and the transfer closes on the first cycle carrying both `data` and `endl`; this may be the completion cycle itself. A cycle without `data`, including `endl` alone, gives error code 3.
- R8: In modes 0, 1 and 3, a data-phase cycle with neither `data` nor `endl` gives error code 3.
- R9: A request seen while a transfer is open (any state but idle) gives error code 4 (overlap) and returns the monitor to idle. This check takes priority over every other check in that cycle.
- R10: `xfer_ok` and `err_pulse` are registered. Each is high for exactly the one cycle after the clock edge that sampled the deciding strobes. The two are never high together, and `err_code` is 0 whenever `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Joining mode: 0/3 split, 1 leading, 2 fused |
| req | input | 1 | Transfer request strobe |
| ack | input | 1 | Acknowledge strobe |
| done | input | 1 | Completion strobe |
| data | input | 1 | Data beat strobe |
| endl | input | 1 | End-of-transfer marker |
| xfer_ok | output | 1 | One-cycle pulse on a correctly closed transfer |
| err_pulse | output | 1 | One-cycle pulse on a rule violation |
| err_code | output | 3 | Violation code (1 no ack, 2 late, 3 framing, 4 overlap), 0 otherwise |

## Verification
The transfer shape is driven at both edges of the completion window: completion after the shortest and the longest legal gap, and one cycle past the longest gap. These runs show whether the counter is off by one at either end. A completion strobe placed in the first gap cycle shows that the window opens late enough.

Each joining mode is run with zero, one and several data beats. These runs separate the modes by whether the completion cycle must carry data and whether the end marker must share a beat. Idle holes and lone end markers in the data phase, a missing acknowledge, and a request inside an open transfer each check that their own code is reported. A reset in the middle of a transfer checks that stale strobes after it are ignored.

// File: rtl/seq_read_mon_pkg.sv
`timescale 1ns/1ps
package seq_read_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_GAP  = 2'd2,
    ST_XFER = 2'd3
  } mon_state_e;

  typedef enum logic [2:0] {
    EC_NONE      = 3'd0,
    EC_NO_ACK    = 3'd1,
    EC_DONE_LATE = 3'd2,
    EC_FRAME     = 3'd3,
    EC_OVERLAP   = 3'd4
  } err_code_e;

  typedef enum logic [1:0] {
    FM_SPLIT = 2'd0,
    FM_LEAD  = 2'd1,
    FM_FUSED = 2'd2,
    FM_ALT   = 2'd3
  } frame_mode_e;

  // true when the given mode demands data on the completion cycle
  function automatic logic mode_needs_lead(input frame_mode_e m);
    return (m == FM_LEAD) || (m == FM_FUSED);
  endfunction

  // true when the given mode demands the end marker to ride on a data beat
  function automatic logic mode_fuses_end(input frame_mode_e m);
    return (m == FM_FUSED);
  endfunction

endpackage

// File: rtl/mon_gap_timer.sv
`timescale 1ns/1ps
module mon_gap_timer #(
  parameter int unsigned MIN_GAP = 1,
  parameter int unsigned MAX_GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic run,
  output logic window_open,
  output logic expired
);
  localparam int unsigned CW = $clog2(MAX_GAP + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_GAP);
  localparam logic [CW-1:0] MAX_V = CW'(MAX_GAP);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || arm)
      gap_cnt <= '0;
    else if (run && (gap_cnt != MAX_V))
      gap_cnt <= gap_cnt + 1'b1;
  end

  assign window_open = (gap_cnt >= MIN_V);
  assign expired     = (gap_cnt == MAX_V);

  a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
    (run && !arm && !expired) |=> (gap_cnt != $past(gap_cnt)));

endmodule

// File: rtl/mon_phase_rules.sv
`timescale 1ns/1ps
module mon_phase_rules
  import seq_read_mon_pkg::*;
(
  input  frame_mode_e mode,
  input  logic        at_done,
  input  logic        data,
  input  logic        endl,
  output logic        finish,
  output logic        bad
);
  logic lead_rule;
  logic fuse_rule;

  assign lead_rule = mode_needs_lead(mode);
  assign fuse_rule = mode_fuses_end(mode);

  always_comb begin
    finish = 1'b0;
    bad    = 1'b0;
    if (fuse_rule) begin
      finish = data && endl;
      bad    = !data;
    end else if (at_done) begin
      bad    = lead_rule && !data;
    end else begin
      finish = endl;
      bad    = !endl && !data;
    end
  end

endmodule

// File: rtl/seq_read_mon.sv
`timescale 1ns/1ps
module seq_read_mon
  import seq_read_mon_pkg::*;
#(
  parameter int unsigned MIN_GAP = 1,
  parameter int unsigned MAX_GAP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       req,
  input  logic       ack,
  input  logic       done,
  input  logic       data,
  input  logic       endl,
  output logic       xfer_ok,
  output logic       err_pulse,
  output logic [2:0] err_code
);
  mon_state_e  state_q, state_n;
  err_code_e   code_q, code_n;
  logic        ok_q, ok_n, err_q, err_n;
  frame_mode_e fmode;

  // named events for the checks below
  logic req_overlap;
  logic gap_arm;
  logic gap_run;
  logic gap_window;
  logic gap_expired;
  logic done_taken;
  logic rule_finish;
  logic rule_bad;

  assign fmode       = frame_mode_e'(mode);
  assign req_overlap = (state_q != ST_IDLE) && req;
  assign gap_run     = (state_q == ST_GAP);
  assign gap_arm     = (state_q == ST_ACK) && ack && !req;
  assign done_taken  = gap_run && done && gap_window;

  mon_gap_timer #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_gap (
    .clk         (clk),
    .rst         (rst),
    .arm         (gap_arm),
    .run         (gap_run),
    .window_open (gap_window),
    .expired     (gap_expired)
  );

  mon_phase_rules u_rules (
    .mode    (fmode),
    .at_done (gap_run),
    .data    (data),
    .endl    (endl),
    .finish  (rule_finish),
    .bad     (rule_bad)
  );

  always_comb begin
    state_n = state_q;
    ok_n    = 1'b0;
    err_n   = 1'b0;
    code_n  = EC_NONE;
    if (req_overlap) begin
      err_n   = 1'b1;
      code_n  = EC_OVERLAP;
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req) state_n = ST_ACK;
        ST_ACK: begin
          if (ack) state_n = ST_GAP;
          else begin
            err_n   = 1'b1;
            code_n  = EC_NO_ACK;
            state_n = ST_IDLE;
          end
        end
        ST_GAP: begin
          if (done_taken) begin
            if (rule_bad) begin
              err_n   = 1'b1;
              code_n  = EC_FRAME;
              state_n = ST_IDLE;
            end else if (rule_finish) begin
              ok_n    = 1'b1;
              state_n = ST_IDLE;
            end else begin
              state_n = ST_XFER;
            end
          end else if (gap_expired) begin
            err_n   = 1'b1;
            code_n  = EC_DONE_LATE;
            state_n = ST_IDLE;
          end
        end
        ST_XFER: begin
          if (rule_bad) begin
            err_n   = 1'b1;
            code_n  = EC_FRAME;
            state_n = ST_IDLE;
          end else if (rule_finish) begin
            ok_n    = 1'b1;
            state_n = ST_IDLE;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= EC_NONE;
    end else begin
      state_q <= state_n;
      ok_q    <= ok_n;
      err_q   <= err_n;
      code_q  <= code_n;
    end
  end

  assign xfer_ok   = ok_q;
  assign err_pulse = err_q;
  assign err_code  = code_q;

  // R10: pulses are exclusive and the code is quiet without an error
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(xfer_ok && err_pulse));
  a_r10_code_quiet: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> (err_code == 3'd0));
  // R1: any verdict leaves the monitor idle
  a_r1_idle_after_verdict: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok || err_pulse) |-> (state_q == ST_IDLE));
  // R2: missing acknowledge is reported next cycle
  a_r2_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && !ack && !req) |=> (err_pulse && err_code == 3'd1));
  // R4: completion past the window is reported
  a_r4_late: assert property (@(posedge clk) disable iff (rst)
    (gap_run && gap_expired && !done && !req) |=> (err_pulse && err_code == 3'd2));
  // R9: request inside an open transfer is reported
  a_r9_overlap: assert property (@(posedge clk) disable iff (rst)
    req_overlap |=> (err_pulse && err_code == 3'd4));
  // R7: in fused mode a success needs data on the closing cycle
  a_r7_fused_close: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && $past(fmode) == FM_FUSED) |-> $past(data && endl));

endmodule

// File: tb/seq_read_mon_bench.sv
`timescale 1ns/1ps
module seq_read_mon_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       req = 1'b0, ack = 1'b0, done = 1'b0, data = 1'b0, endl = 1'b0;
  logic       xfer_ok, err_pulse;
  logic [2:0] err_code;
  int         vecs = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  seq_read_mon u_seq_read_mon (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .ack(ack), .done(done),
    .data(data), .endl(endl), .xfer_ok(xfer_ok), .err_pulse(err_pulse),
    .err_code(err_code)
  );

  // drive one cycle of strobes, then look just after the edge that samples them
  task automatic step(input logic r, input logic a, input logic d,
                      input logic dt, input logic e);
    req = r; ack = a; done = d; data = dt; endl = e;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic eok,
                            input logic eerr, input logic [2:0] ecode);
    vecs++;
    if (xfer_ok !== eok || err_pulse !== eerr || err_code !== ecode) begin
      fails++;
      $display("FAIL %s: got ok=%0b err=%0b code=%0d, expected ok=%0b err=%0b code=%0d",
               tag, xfer_ok, err_pulse, err_code, eok, eerr, ecode);
    end
  endtask

  task automatic settle();
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_state();
    expect_out("R1 after reset", 0, 0, 0);
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rst = 1'b1;
    step(0, 0, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R1 stale strobes after mid reset", 0, 0, 0);
  endtask

  task automatic t_split_min_gap();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    expect_out("R3 done after one gap cycle", 0, 0, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R5 zero beats closes", 1, 0, 0);
    settle();
    expect_out("R10 ok is one cycle", 0, 0, 0);
  endtask

  task automatic t_split_max_gap();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    expect_out("R3 done after four gap cycles", 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R5 two beats then end", 1, 0, 0);
    settle();
  endtask

  task automatic t_early_done_ignored();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    expect_out("R3 done in first gap cycle ignored", 0, 0, 0);
    step(0, 0, 0, 0, 0);
    expect_out("R3 still waiting after early done", 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R3 later done accepted", 1, 0, 0);
    settle();
  endtask

  task automatic t_no_ack();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    expect_out("R2 missing ack", 0, 1, 3'd1);
    settle();
    expect_out("R10 err is one cycle", 0, 0, 0);
  endtask

  task automatic t_timeout();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    expect_out("R4 no error at fourth gap cycle", 0, 0, 0);
    step(0, 0, 0, 0, 0);
    expect_out("R4 late completion", 0, 1, 3'd2);
    settle();
  endtask

  task automatic t_lead_mode();
    mode = 2'd1;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R6 leading beat accepted", 1, 0, 0);
    settle();
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    expect_out("R6 done without data", 0, 1, 3'd3);
    settle();
  endtask

  task automatic t_fused_mode();
    mode = 2'd2;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    expect_out("R7 end rides last beat", 1, 0, 0);
    settle();
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1);
    expect_out("R7 single fused cycle", 1, 0, 0);
    settle();
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R7 end without data", 0, 1, 3'd3);
    settle();
  endtask

  task automatic t_split_hole();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    expect_out("R8 idle hole in data phase", 0, 1, 3'd3);
    settle();
  endtask

  task automatic t_alt_mode();
    mode = 2'd3;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R5 mode 3 behaves as split", 1, 0, 0);
    settle();
  endtask

  task automatic t_overlap();
    mode = 2'd0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    expect_out("R9 request during gap", 0, 1, 3'd4);
    settle();
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    expect_out("R9 monitor idle after overlap", 0, 0, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset_state();
    t_split_min_gap();
    t_split_max_gap();
    t_early_done_ignored();
    t_no_ack();
    t_timeout();
    t_lead_mode();
    t_fused_mode();
    t_split_hole();
    t_alt_mode();
    t_overlap();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule